// File: doc/BRIEF.md
# Pipelined Burst SRAM

A single-port synchronous static memory for cache and buffer use. Every input is captured on the rising clock edge, and reads are pipelined through a registered output stage, so read data comes out one cycle after its address is sampled. A 2-bit burst counter lets a host load one address and then step through the other words of its aligned four-word group, one word per clock. The step order is either interleaved or linear, chosen when the address is loaded.

Three chip selects allow depth expansion. Writes use per-lane byte enables, which are qualified by a common lane gate, or a global write that covers every lane. The bidirectional data bus is modelled as separate write-data and read-data buses plus a drive flag, and an asynchronous output enable gates that flag. A sleep input freezes the block: accesses are ignored, while the memory contents and the burst position are kept.

Top module: `burst_sram`

## Requirements
- R1: During and straight after reset, `rdata_oe` is 0.
- R2: A selected load cycle (`addr_load`=1) that is not a write reads the word at `addr`. In the next cycle `rdata` holds that word and `rdata_oe`=1, provided `out_en_n`=0.
- R3: The chip is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A load cycle with any select inactive performs no access, ends the burst, and turns the output off (`rdata_oe`=0) in the next cycle.
- R4: When `burst_linear`=0 at load, each `burst_adv` cycle of an active burst with `addr_load`=0 increments a 2-bit step count. The count wraps from 3 to 0. The word accessed has the upper address bits of the loaded address and low bits equal to the loaded low two bits XOR the step count.
- R5: When `burst_linear`=1 at load, the low two address bits of each access are the loaded low two bits plus the step count, modulo 4.
- R6: With `lane_gate_n`=0 and `wr_all_n`=1, a write updates only the lanes whose `lane_wr_n[i]`=0. Lane i is bits [8i+7:8i]. The other lanes keep their contents.
- R7: With `wr_all_n`=0, an access writes all lanes whatever the values of `lane_gate_n` and `lane_wr_n`.
- R8: An access with `wr_all_n`=1 and no lane enabled, because `lane_gate_n`=1 or `lane_wr_n` is all ones, is handled as a read.
- R9: While `pwr_sleep`=1, loads, advances and writes have no effect, memory and burst position are kept, and `rdata_oe`=0. After `pwr_sleep` returns to 0, the burst continues from its held step.
- R10: `out_en_n`=1 forces `rdata_oe` to 0 in the same cycle, with no effect on the read pipeline.
- R11: The cycle after a write access has `rdata_oe`=0.
- R12: A cycle with neither a load nor an advance of an active burst performs no access, and the next cycle has `rdata_oe`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_sleep | input | 1 | Power-down: freeze and ignore accesses |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| addr_load | input | 1 | Load new address and start a burst |
| burst_adv | input | 1 | Advance the burst by one word |
| burst_linear | input | 1 | Burst order at load: 1 linear, 0 interleaved |
| wr_all_n | input | 1 | Global write, all lanes, active low |
| lane_gate_n | input | 1 | Common qualifier for lane writes, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | AW | Word address |
| wdata | input | LANES*LW | Write data |
| rdata | output | LANES*LW | Read data (zero when not driven) |
| rdata_oe | output | 1 | Data bus drive flag |

## Verification
A corrupted step count or stored base shows up on the very next read of a burst as a word taken from the wrong slot of its four-word group. A wrong selection or valid flag shows up one cycle after the event as a bus driven when it should float, or floating when it should be driven. A lane enable decoded wrongly stays hidden until the word is read back, when a single byte of it differs. Because of this, each write is followed by a read, and every cycle's drive flag is compared, including during sleep and right after it.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
    typedef enum logic {
        ORDER_XOR = 1'b0,
        ORDER_INC = 1'b1
    } burst_order_e;
endpackage

// File: rtl/burst_seq.sv
module burst_seq
    import burst_sram_pkg::*;
(
    input  logic [1:0]   base_lo,
    input  logic [1:0]   step,
    input  burst_order_e order,
    output logic [1:0]   offset
);
    always_comb begin
        unique case (order)
            ORDER_INC: offset = base_lo + step;
            default:   offset = base_lo ^ step;
        endcase
    end
endmodule

// File: rtl/lane_ram.sv
module lane_ram #(
    parameter int AW = 8,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] wd,
    output logic [LW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [LW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wd;
    end

    assign rd = mem[addr];
endmodule

// File: rtl/burst_sram.sv
module burst_sram
    import burst_sram_pkg::*;
#(
    parameter int AW    = 8,
    parameter int LANES = 4,
    parameter int LW    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_sleep,
    input  logic                sel_a_n,
    input  logic                sel_b,
    input  logic                sel_c_n,
    input  logic                addr_load,
    input  logic                burst_adv,
    input  logic                burst_linear,
    input  logic                wr_all_n,
    input  logic                lane_gate_n,
    input  logic [LANES-1:0]    lane_wr_n,
    input  logic                out_en_n,
    input  logic [AW-1:0]       addr,
    input  logic [LANES*LW-1:0] wdata,
    output logic [LANES*LW-1:0] rdata,
    output logic                rdata_oe
);
    localparam int DW = LANES * LW;

    typedef struct packed {
        logic         active;
        logic [AW-1:0] base;
        logic [1:0]   step;
        burst_order_e order;
        logic         valid;
        logic [DW-1:0] rdata;
    } state_t;

    state_t state_d, state_q;

    logic             chip_sel;
    logic             lane_any;
    logic             is_wr;
    logic             acc;
    logic [AW-1:0]    acc_addr;
    logic [1:0]       step_nx;
    logic [1:0]       adv_off;
    logic [DW-1:0]    mem_rd;
    logic [LANES-1:0] lane_we;

    assign chip_sel = ~sel_a_n & sel_b & ~sel_c_n;
    assign lane_any = ~lane_gate_n & (|(~lane_wr_n));
    assign is_wr    = ~wr_all_n | lane_any;
    assign step_nx  = state_q.step + 2'd1;

    burst_seq u_seq (
        .base_lo (state_q.base[1:0]),
        .step    (step_nx),
        .order   (state_q.order),
        .offset  (adv_off)
    );

    always_comb begin
        if (addr_load) begin
            acc      = chip_sel;
            acc_addr = addr;
        end else begin
            acc      = burst_adv & state_q.active;
            acc_addr = {state_q.base[AW-1:2], adv_off};
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = ~pwr_sleep & acc & is_wr &
                            (~wr_all_n | (~lane_gate_n & ~lane_wr_n[i]));
        lane_ram #(.AW(AW), .LW(LW)) u_ram (
            .clk  (clk),
            .we   (lane_we[i]),
            .addr (acc_addr),
            .wd   (wdata[i*LW +: LW]),
            .rd   (mem_rd[i*LW +: LW])
        );
    end

    always_comb begin
        state_d = state_q;
        if (!pwr_sleep) begin
            if (addr_load) begin
                state_d.active = chip_sel;
                if (chip_sel) begin
                    state_d.base  = addr;
                    state_d.step  = 2'd0;
                    state_d.order = burst_linear ? ORDER_INC : ORDER_XOR;
                end
            end else if (burst_adv && state_q.active) begin
                state_d.step = step_nx;
            end
            state_d.valid = acc & ~is_wr;
            if (acc && !is_wr) state_d.rdata = mem_rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rdata_oe = state_q.valid & ~out_en_n & ~pwr_sleep;
    assign rdata    = rdata_oe ? state_q.rdata : '0;

    // R2: selected read load yields valid data next cycle
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_sleep && addr_load && chip_sel && !is_wr) |=> state_q.valid);

    // R3: deselecting load stops the output one cycle later
    p_deselect_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_sleep && addr_load && !chip_sel) |=> (!state_q.valid && !rdata_oe));

    // R4: advancing step counts by one and wraps in two bits
    p_step_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_sleep && !addr_load && burst_adv && state_q.active)
        |=> (state_q.step == 2'($past(state_q.step) + 2'd1)));

    // R9: sleep freezes burst position and output register
    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_sleep |=> ($stable(state_q.step) && $stable(state_q.base) &&
                       $stable(state_q.rdata) && $stable(state_q.active)));

    // R10: output enable high never drives the bus
    p_oe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !rdata_oe);

    // R11: write access leaves the bus floating next cycle
    p_write_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_sleep && acc && is_wr) |=> !rdata_oe);

    // R6: no lane is written while asleep or without an access
    p_lane_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_sleep || !acc) |-> (lane_we == '0));
endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;
    localparam int AW = 8, LANES = 4, LW = 8, DW = 32;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, slp, sa_n, sb, sc_n, ld, adv, lin, wa_n, gate_n, oe_n;
    logic [LANES-1:0] lane_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata, rdata;
    logic rdata_oe;

    burst_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_sleep(slp), .sel_a_n(sa_n), .sel_b(sb),
        .sel_c_n(sc_n), .addr_load(ld), .burst_adv(adv), .burst_linear(lin),
        .wr_all_n(wa_n), .lane_gate_n(gate_n), .lane_wr_n(lane_n), .out_en_n(oe_n),
        .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    typedef struct {
        bit            oe;
        logic [DW-1:0] d;
        string         tag;
    } exp_t;

    exp_t q[$];
    int n_run = 0, n_fail = 0;

    bit            m_act = 0, m_lin = 0, m_val = 0;
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    logic [DW-1:0] m_rd = '0;
    logic [DW-1:0] mm [0:(1<<AW)-1];

    task automatic idle_in();
        ld = 0; adv = 0; lin = 0; sa_n = 0; sb = 1; sc_n = 0; wa_n = 1;
        gate_n = 1; lane_n = '1; oe_n = 0; slp = 0; addr = '0; wdata = '0;
    endtask

    task automatic cyc(input string tag);
        bit sel, wr, acc;
        logic [AW-1:0] a;
        logic [1:0] s1, off;
        exp_t e;
        @(posedge clk);
        if (!slp) begin
            sel = !sa_n && sb && !sc_n;
            wr  = !wa_n || (!gate_n && lane_n != '1);
            acc = 0;
            a   = addr;
            if (ld) begin
                acc = sel;
                m_act = sel;
                if (sel) begin m_base = addr; m_step = 0; m_lin = lin; end
            end else if (adv && m_act) begin
                s1  = m_step + 2'd1;
                off = m_lin ? m_base[1:0] + s1 : m_base[1:0] ^ s1;
                a   = {m_base[AW-1:2], off};
                m_step = s1;
                acc = 1;
            end
            if (acc && wr)
                for (int i = 0; i < LANES; i++)
                    if (!wa_n || (!gate_n && !lane_n[i])) mm[a][i*LW +: LW] = wdata[i*LW +: LW];
            m_val = acc && !wr;
            if (m_val) m_rd = mm[a];
        end
        e.oe = m_val && !oe_n && !slp;
        e.d = m_rd;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        idle_in();
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        ld = 1; addr = a; wa_n = 0; wdata = d; cyc(tag);
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        ld = 1; addr = a; cyc(tag);
    endtask

    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                n_run++;
                if (e.oe) begin
                    if (rdata_oe !== 1'b1 || rdata !== e.d) begin
                        n_fail++;
                        $display("FAIL %s: oe=%b rdata=%h expected oe=1 rdata=%h", e.tag, rdata_oe, rdata, e.d);
                    end
                end else if (rdata_oe !== 1'b0) begin
                    n_fail++;
                    $display("FAIL %s: oe=%b expected oe=0", e.tag, rdata_oe);
                end
            end
        end
    end

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        n_run++;
        if (rdata_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: oe=%b expected 0", rdata_oe);
        end
        rst_n = 1;
        cyc("R1 after reset");

        // R7 / R11: fill words 0..15 with global writes, lanes gate ignored
        for (int i = 0; i < 16; i++) begin
            lane_n = 4'b1010;
            wr_all(AW'(i), {8'(i + 8'hC0), 8'(i + 8'h80), 8'(i + 8'h40), 8'(i + 1)}, "R7 R11 write fill");
        end
        for (int i = 0; i < 16; i++) rd(AW'(i), "R2 single read");

        // R4: interleaved burst from offset 2 (word 6), five steps incl wrap
        rd(8'd6, "R4 load");
        for (int k = 0; k < 5; k++) begin adv = 1; cyc("R4 xor burst"); end

        // R5: linear burst from offset 1 (word 5)
        lin = 1; rd(8'd5, "R5 load");
        for (int k = 0; k < 5; k++) begin adv = 1; cyc("R5 linear burst"); end

        // R5 / R7: linear burst write from word 14
        lin = 1; wr_all(8'd14, 32'hDEAD_0E0E, "R5 burst write load");
        adv = 1; wa_n = 0; wdata = 32'hDEAD_0F0F; cyc("R5 burst write");
        adv = 1; wa_n = 0; wdata = 32'hDEAD_0C0C; cyc("R5 burst write wrap");
        for (int i = 12; i < 16; i++) rd(AW'(i), "R5 burst write readback");

        // R6: partial byte write, lanes 1 and 3
        ld = 1; addr = 8'd3; gate_n = 0; lane_n = 4'b0101; wdata = 32'h1122_3344; cyc("R6 lane write");
        rd(8'd3, "R6 lane readback");
        ld = 1; addr = 8'd4; gate_n = 0; lane_n = 4'b1110; wdata = 32'h5566_7788; cyc("R6 lane0 write");
        rd(8'd4, "R6 lane0 readback");

        // R7: global write overrides lane enables
        ld = 1; addr = 8'd2; wa_n = 0; gate_n = 0; lane_n = 4'b0111; wdata = 32'hCAFE_F00D; cyc("R7 global override");
        rd(8'd2, "R7 readback");

        // R8: write strobes with no lane enabled act as reads
        ld = 1; addr = 8'd7; gate_n = 0; lane_n = '1; wdata = 32'hFFFF_FFFF; cyc("R8 no lane read");
        ld = 1; addr = 8'd8; gate_n = 1; lane_n = '0; wdata = 32'hFFFF_FFFF; cyc("R8 ungated read");
        rd(8'd8, "R8 unchanged");

        // R3: each select inactive in turn, then R12 idle after deselect
        rd(8'd1, "R3 read before");
        ld = 1; addr = 8'd1; sa_n = 1; cyc("R3 sel_a inactive");
        adv = 1; cyc("R12 adv without burst");
        rd(8'd1, "R3 reselect");
        ld = 1; addr = 8'd1; sb = 0; cyc("R3 sel_b inactive");
        rd(8'd9, "R3 reselect");
        ld = 1; addr = 8'd9; sc_n = 1; wa_n = 0; wdata = 32'h0BAD_0BAD; cyc("R3 sel_c inactive write");
        rd(8'd9, "R3 write blocked");
        cyc("R12 idle");

        // R9: sleep mid-burst with attempted accesses
        rd(8'd8, "R9 load");
        adv = 1; cyc("R9 adv");
        for (int k = 0; k < 3; k++) begin
            slp = 1; ld = 1; adv = 1; wa_n = 0; addr = 8'd9; wdata = 32'h5EE5_5EE5; cyc("R9 asleep");
        end
        adv = 1; cyc("R9 resume");
        adv = 1; cyc("R9 resume 2");
        rd(8'd9, "R9 memory kept");

        // R10: output enable gates the bus only
        oe_n = 1; rd(8'd10, "R10 oe high");
        adv = 1; cyc("R10 pipeline kept");
        oe_n = 1; adv = 1; cyc("R10 oe high burst");
        adv = 1; cyc("R10 after release");

        repeat (3) cyc("R12 drain");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule